// File: doc/BRIEF.md
# LDPC Decode Trial Controller

This block runs a fully parallel iterative LDPC decoder through one trial at a time and sorts each trial into one of three outcomes. A host loads the soft input frame (one LLR per code bit), the frame that was actually transmitted, and an iteration budget through a small word-wide write port. It then pulses `start`. The controller holds the decoder in reset for one cycle and applies the LLRs for one cycle. It then lets the decoder run, counting one iteration for every two run cycles.

A trial ends in one of two ways. If the decoder reports that all parity checks are satisfied, its output is captured and compared with the transmitted frame. The result is a clean decode or a wrong valid codeword. If the iteration budget runs out first, the trial is abandoned.

Only failed trials have their bit errors counted. The controller scans the captured output against the transmitted frame one word per cycle and adds the number of differing bits to a saturating counter. A second saturating counter counts failed trials. Both counters keep accumulating across trials until the host clears them, so a long run of frames gives the frame and bit error statistics directly.

Top module: `ldpc_trial_ctrl`

## Requirements
- R1: After reset the block is idle with `busy`, `dec_rst`, `dec_load`, `dec_run` and `result_valid` low. `status` is 0 (no result yet), both counters are zero and the iteration budget is 100.
- R2: A `start` seen while idle drives `dec_rst` high for exactly one cycle, then `dec_load` high for exactly one cycle, then `dec_run` high until the trial ends. `busy` stays high from the `dec_rst` cycle to the `result_valid` cycle inclusive. A `start` seen while busy has no effect.
- R3: During the run, `iter_cnt` starts at 0 and rises by one every second run cycle. After the run it holds its final value.
- R4: If `dec_done` is high in a run cycle and the decoder frame equals the transmitted frame, `status` becomes 1 (clean decode). Neither counter changes, and `result_valid` pulses two cycles after that run cycle.
- R5: If `dec_done` is high in a run cycle and the decoder frame differs from the transmitted frame, `status` becomes 3 (wrong codeword).
- R6: If `iter_cnt` equals the budget in a run cycle without `dec_done`, the trial gives up and `status` becomes 2. With budget M and no `dec_done`, the run lasts 2M+1 cycles, and a budget of 0 gives up in the first run cycle.
- R7: When `dec_done` arrives in the same run cycle in which `iter_cnt` reaches the budget, `dec_done` takes priority and the trial is classified by the frame comparison.
- R8: On a failed trial (status 2 or 3), `bit_err_cnt` grows by the number of bits in which the captured decoder frame differs from the transmitted frame. The scan covers FRAME_N/WORD_W words, one per cycle, and the counter saturates at its maximum.
- R9: `frame_err_cnt` rises by one, saturating, for each failed trial and not for a clean decode.
- R10: `result_valid` is a single-cycle pulse at the end of each trial, and the block is idle in the following cycle.
- R11: A `clr_cnt` pulse zeroes both counters in the next cycle.
- R12: Host writes while idle work by `host_sel`. 0 writes LLR word `host_idx` into `dec_llr[host_idx*WORD_W +: WORD_W]`. 1 writes transmitted-frame word `host_idx` (bits `host_idx*WORD_W` upward). 2 writes the iteration budget from the low ITER_W bits of `host_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 LLR, 1 transmitted frame, 2 iteration budget |
| host_idx | input | IDX_W | Word index within the selected target |
| host_wdata | input | WORD_W | Write data |
| start | input | 1 | Begin one trial |
| clr_cnt | input | 1 | Zero both error counters |
| dec_rst | output | 1 | Decoder reset |
| dec_load | output | 1 | Decoder takes the LLR frame |
| dec_run | output | 1 | Decoder iterates |
| dec_llr | output | FRAME_N*LLR_W | LLR frame to the decoder |
| dec_done | input | 1 | Decoder: all parity checks satisfied |
| dec_frame | input | FRAME_N | Decoder hard-decision output |
| busy | output | 1 | Trial in progress |
| result_valid | output | 1 | One-cycle end-of-trial pulse |
| status | output | 2 | 0 none, 1 clean, 2 gave up, 3 wrong codeword |
| iter_cnt | output | ITER_W | Iterations counted in the current or last trial |
| bit_err_cnt | output | CNT_W | Accumulated bit errors |
| frame_err_cnt | output | CNT_W | Accumulated failed trials |

## Verification
The interesting collision is `dec_done` arriving in the very run cycle in which the iteration count hits the budget. Both the convergence path and the give-up path want the same exit edge. The bench provokes it by setting the budget to M and making the decoder stub converge after exactly M iterations, once with the transmitted frame and once with a corrupted one. It then expects the comparison outcome (status 1 or 3) rather than a give-up, along with the matching counter deltas and exit cycle.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_CLEAN  = 2'd1,
    OUT_GAVEUP = 2'd2,
    OUT_WRONG  = 2'd3
  } outcome_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RESET,
    SQ_LOAD,
    SQ_RUN,
    SQ_CHECK,
    SQ_SCAN,
    SQ_FIN
  } seq_t;

  localparam logic [1:0] TGT_LLR   = 2'd0;
  localparam logic [1:0] TGT_GOLD  = 2'd1;
  localparam logic [1:0] TGT_LIMIT = 2'd2;

endpackage

// File: rtl/dtm_host_regs.sv
module dtm_host_regs
  import dtm_pkg::*;
#(
  parameter int FRAME_N      = 64,
  parameter int LLR_W        = 4,
  parameter int WORD_W       = 16,
  parameter int ITER_W       = 8,
  parameter int LIMIT_RST    = 100,
  parameter int IDX_W        = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busy,
  input  logic                       wr,
  input  logic [1:0]                 sel,
  input  logic [IDX_W-1:0]           idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [FRAME_N*LLR_W-1:0]   llr_flat,
  output logic [FRAME_N-1:0]         gold_flat,
  output logic [ITER_W-1:0]          limit
);

  localparam int LLR_WORDS  = FRAME_N * LLR_W / WORD_W;
  localparam int GOLD_WORDS = FRAME_N / WORD_W;

  logic wr_ok;
  assign wr_ok = wr && !busy;

  logic [WORD_W-1:0] llr_q  [LLR_WORDS];
  logic [WORD_W-1:0] gold_q [GOLD_WORDS];

  for (genvar i = 0; i < LLR_WORDS; i++) begin : g_llr
    always_ff @(posedge clk) begin
      if (rst)
        llr_q[i] <= '0;
      else if (wr_ok && sel == TGT_LLR && idx == IDX_W'(i))
        llr_q[i] <= wdata;
    end
    assign llr_flat[i*WORD_W +: WORD_W] = llr_q[i];
  end

  for (genvar g = 0; g < GOLD_WORDS; g++) begin : g_gold
    always_ff @(posedge clk) begin
      if (rst)
        gold_q[g] <= '0;
      else if (wr_ok && sel == TGT_GOLD && idx == IDX_W'(g))
        gold_q[g] <= wdata;
    end
    assign gold_flat[g*WORD_W +: WORD_W] = gold_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)
      limit <= ITER_W'(LIMIT_RST);
    else if (wr_ok && sel == TGT_LIMIT)
      limit <= wdata[ITER_W-1:0];
  end

  // R12
  limit_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !busy && sel == TGT_LIMIT) |=> (limit == $past(wdata[ITER_W-1:0])));

  // R12
  limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(limit));

endmodule

// File: rtl/dtm_seq.sv
module dtm_seq
  import dtm_pkg::*;
#(
  parameter int ITER_W = 8,
  parameter int WIDX_W = 2,
  parameter int NWORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dec_done,
  input  logic              frame_eq,
  input  logic [ITER_W-1:0] limit,
  output logic              dec_rst,
  output logic              dec_load,
  output logic              dec_run,
  output logic              busy,
  output logic              result_valid,
  output logic [1:0]        status,
  output logic [ITER_W-1:0] iter_cnt,
  output logic              capture,
  output logic              scan_en,
  output logic [WIDX_W-1:0] widx,
  output logic              fail_inc
);

  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NWORDS - 1);

  seq_t     state, nxt;
  logic     phase;
  outcome_t outc;

  always_comb begin
    nxt = state;
    case (state)
      SQ_IDLE:  if (start) nxt = SQ_RESET;
      SQ_RESET: nxt = SQ_LOAD;
      SQ_LOAD:  nxt = SQ_RUN;
      SQ_RUN: begin
        if (dec_done)              nxt = SQ_CHECK;
        else if (iter_cnt == limit) nxt = SQ_SCAN;
      end
      SQ_CHECK: nxt = frame_eq ? SQ_FIN : SQ_SCAN;
      SQ_SCAN:  if (widx == LAST_W) nxt = SQ_FIN;
      SQ_FIN:   nxt = SQ_IDLE;
      default:  nxt = SQ_IDLE;
    endcase
  end

  assign capture  = (state == SQ_RUN) && (nxt != SQ_RUN);
  assign scan_en  = (state == SQ_SCAN);
  assign fail_inc = (state == SQ_SCAN) && (nxt == SQ_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      dec_rst      <= 1'b0;
      dec_load     <= 1'b0;
      dec_run      <= 1'b0;
      busy         <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      state        <= nxt;
      dec_rst      <= (nxt == SQ_RESET);
      dec_load     <= (nxt == SQ_LOAD);
      dec_run      <= (nxt == SQ_RUN);
      busy         <= (nxt != SQ_IDLE);
      result_valid <= (nxt == SQ_FIN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iter_cnt <= '0;
      phase    <= 1'b0;
    end else if (state == SQ_LOAD) begin
      iter_cnt <= '0;
      phase    <= 1'b0;
    end else if (state == SQ_RUN && nxt == SQ_RUN) begin
      phase <= ~phase;
      if (phase) iter_cnt <= iter_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state != SQ_SCAN) widx <= '0;
    else                         widx <= widx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      outc <= OUT_NONE;
    else if (state == SQ_RUN && nxt == SQ_SCAN)
      outc <= OUT_GAVEUP;
    else if (state == SQ_CHECK)
      outc <= frame_eq ? OUT_CLEAN : OUT_WRONG;
  end
  assign status = outc;

  // R2
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_rst |=> (!dec_rst && dec_load));

  // R2
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_load |=> (!dec_load && dec_run));

  // R3
  iter_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_run && $past(dec_run)) |-> (iter_cnt == $past(iter_cnt) || iter_cnt == $past(iter_cnt) + 1'b1));

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dec_run |-> (iter_cnt <= limit));

  // R10
  result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> (!result_valid && !busy));

  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_rst || dec_load || dec_run || result_valid) |-> busy);

endmodule

// File: rtl/dtm_err_acc.sv
module dtm_err_acc #(
  parameter int FRAME_N = 64,
  parameter int WORD_W  = 16,
  parameter int CNT_W   = 16,
  parameter int WIDX_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [FRAME_N-1:0] dec_frame,
  input  logic [FRAME_N-1:0] gold,
  input  logic               scan_en,
  input  logic [WIDX_W-1:0]  widx,
  input  logic               fail_inc,
  input  logic               clr,
  output logic               frame_eq,
  output logic [CNT_W-1:0]   bit_err,
  output logic [CNT_W-1:0]   frame_err
);

  localparam int PC_W = $clog2(WORD_W + 1);

  logic [FRAME_N-1:0] out_q;
  logic [WORD_W-1:0]  diff_w;
  logic [PC_W-1:0]    pc;
  logic [CNT_W:0]     bit_sum;
  logic [CNT_W:0]     frm_sum;

  function automatic logic [PC_W-1:0] ones(input logic [WORD_W-1:0] w);
    logic [PC_W-1:0] n;
    n = '0;
    for (int b = 0; b < WORD_W; b++) n = n + PC_W'(w[b]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          out_q <= '0;
    else if (capture) out_q <= dec_frame;
  end

  assign frame_eq = (out_q == gold);
  assign diff_w   = out_q[int'(widx)*WORD_W +: WORD_W] ^ gold[int'(widx)*WORD_W +: WORD_W];
  assign pc       = ones(diff_w);
  assign bit_sum  = {1'b0, bit_err} + (CNT_W+1)'(pc);
  assign frm_sum  = {1'b0, frame_err} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      bit_err <= '0;
    else if (scan_en)
      bit_err <= bit_sum[CNT_W] ? {CNT_W{1'b1}} : bit_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      frame_err <= '0;
    else if (fail_inc)
      frame_err <= frm_sum[CNT_W] ? {CNT_W{1'b1}} : frm_sum[CNT_W-1:0];
  end

  // R8
  bit_err_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (bit_err >= $past(bit_err)));

  // R8
  bit_err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !scan_en) |=> $stable(bit_err));

  // R9
  frame_err_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (frame_err == $past(frame_err) || frame_err == $past(frame_err) + 1'b1));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bit_err == '0 && frame_err == '0));

endmodule

// File: rtl/ldpc_trial_ctrl.sv
module ldpc_trial_ctrl
  import dtm_pkg::*;
#(
  parameter int FRAME_N   = 64,
  parameter int LLR_W     = 4,
  parameter int WORD_W    = 16,
  parameter int ITER_W    = 8,
  parameter int LIMIT_RST = 100,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = $clog2(FRAME_N * LLR_W / WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic [1:0]               host_sel,
  input  logic [IDX_W-1:0]         host_idx,
  input  logic [WORD_W-1:0]        host_wdata,
  input  logic                     start,
  input  logic                     clr_cnt,
  output logic                     dec_rst,
  output logic                     dec_load,
  output logic                     dec_run,
  output logic [FRAME_N*LLR_W-1:0] dec_llr,
  input  logic                     dec_done,
  input  logic [FRAME_N-1:0]       dec_frame,
  output logic                     busy,
  output logic                     result_valid,
  output logic [1:0]               status,
  output logic [ITER_W-1:0]        iter_cnt,
  output logic [CNT_W-1:0]         bit_err_cnt,
  output logic [CNT_W-1:0]         frame_err_cnt
);

  localparam int NWORDS = FRAME_N / WORD_W;
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [FRAME_N-1:0] gold;
  logic [ITER_W-1:0]  limit;
  logic               capture, scan_en, fail_inc, frame_eq;
  logic [WIDX_W-1:0]  widx;

  dtm_host_regs #(
    .FRAME_N(FRAME_N), .LLR_W(LLR_W), .WORD_W(WORD_W),
    .ITER_W(ITER_W), .LIMIT_RST(LIMIT_RST), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .busy(busy),
    .wr(host_wr), .sel(host_sel), .idx(host_idx), .wdata(host_wdata),
    .llr_flat(dec_llr), .gold_flat(gold), .limit(limit)
  );

  dtm_seq #(
    .ITER_W(ITER_W), .WIDX_W(WIDX_W), .NWORDS(NWORDS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .dec_done(dec_done),
    .frame_eq(frame_eq), .limit(limit),
    .dec_rst(dec_rst), .dec_load(dec_load), .dec_run(dec_run),
    .busy(busy), .result_valid(result_valid), .status(status),
    .iter_cnt(iter_cnt), .capture(capture), .scan_en(scan_en),
    .widx(widx), .fail_inc(fail_inc)
  );

  dtm_err_acc #(
    .FRAME_N(FRAME_N), .WORD_W(WORD_W), .CNT_W(CNT_W), .WIDX_W(WIDX_W)
  ) u_acc (
    .clk(clk), .rst(rst), .capture(capture), .dec_frame(dec_frame),
    .gold(gold), .scan_en(scan_en), .widx(widx), .fail_inc(fail_inc),
    .clr(clr_cnt), .frame_eq(frame_eq),
    .bit_err(bit_err_cnt), .frame_err(frame_err_cnt)
  );

endmodule

// File: tb/sim_ldpc_trial_ctrl.sv
module sim_ldpc_trial_ctrl;

  localparam int N    = 64;
  localparam int LW   = 4;
  localparam int WW   = 16;
  localparam int IW   = 8;
  localparam int CW   = 16;
  localparam int LLRN = N * LW / WW;
  localparam int GN   = N / WW;
  localparam int XW   = $clog2(LLRN);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           host_wr = 1'b0;
  logic [1:0]     host_sel = '0;
  logic [XW-1:0]  host_idx = '0;
  logic [WW-1:0]  host_wdata = '0;
  logic           start = 1'b0;
  logic           clr_cnt = 1'b0;
  logic           dec_rst, dec_load, dec_run, dec_done;
  logic [N*LW-1:0] dec_llr;
  logic [N-1:0]   dec_frame;
  logic           busy, result_valid;
  logic [1:0]     status;
  logic [IW-1:0]  iter_cnt;
  logic [CW-1:0]  bit_err_cnt, frame_err_cnt;

  always #2 clk = ~clk;

  ldpc_trial_ctrl #(.FRAME_N(N), .LLR_W(LW), .WORD_W(WW), .ITER_W(IW),
                    .LIMIT_RST(100), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_idx(host_idx), .host_wdata(host_wdata), .start(start),
    .clr_cnt(clr_cnt), .dec_rst(dec_rst), .dec_load(dec_load),
    .dec_run(dec_run), .dec_llr(dec_llr), .dec_done(dec_done),
    .dec_frame(dec_frame), .busy(busy), .result_valid(result_valid),
    .status(status), .iter_cnt(iter_cnt), .bit_err_cnt(bit_err_cnt),
    .frame_err_cnt(frame_err_cnt)
  );

  // Behavioural decoder stub: converges after stub_k iterations (never if negative)
  int          stub_k = -1;
  int          stub_j = 0;
  logic [N-1:0] stub_frame = '0;
  always @(posedge clk) begin
    if (dec_load)     stub_j <= 0;
    else if (dec_run) stub_j <= stub_j + 1;
  end
  assign dec_done  = dec_run && (stub_k >= 0) && (stub_j >= 2 * stub_k);
  assign dec_frame = stub_frame;

  int compared = 0, mismatched = 0;
  int exp_bit = 0, exp_ferr = 0, exp_stat = 0, cur_max = 100;
  logic [N-1:0] gold_m = '0;
  bit finished = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] s, input int i, input logic [WW-1:0] d);
    host_wr = 1'b1; host_sel = s; host_idx = XW'(i); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (s == 2'd2) cur_max = int'(d[IW-1:0]);
    if (s == 2'd1) gold_m[i*WW +: WW] = d;
  endtask

  // Drives one trial and compares every cycle against a timeline derived from the requirements
  task automatic run_trial(input int k, input logic [N-1:0] of, input bit extra_start);
    int  jx, tc, tfin, ts, tbs, errs, nstat;
    bit  dn, ok;
    string tag;
    stub_k = k; stub_frame = of;
    dn   = (k >= 0) && (k <= cur_max);
    jx   = dn ? 2 * k : 2 * cur_max;
    tc   = 4 + jx;
    errs = $countones(of ^ gold_m);
    ok   = dn && (errs == 0);
    if (ok)      begin tfin = tc + 1;      ts = tc + 1; tbs = 1 << 30; nstat = 1; tag = "R4"; end
    else if (dn) begin tfin = tc + GN + 1; ts = tc + 1; tbs = tc + 1;  nstat = 3; tag = "R5"; end
    else         begin tfin = 4 + jx + GN; ts = 4 + jx; tbs = 4 + jx;  nstat = 2; tag = "R6"; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 1; t <= tfin + 1; t++) begin
      chk("R2 busy", busy, t <= tfin);
      chk("R2 dec_rst", dec_rst, t == 1);
      chk("R2 dec_load", dec_load, t == 2);
      chk({tag, " dec_run window"}, dec_run, (t >= 3) && (t <= 3 + jx));
      chk("R10 result_valid", result_valid, t == tfin);
      chk({tag, " status"}, status, (t >= ts) ? nstat : exp_stat);
      if (t >= 3) chk("R3 iter_cnt", iter_cnt, ((t - 3 < jx) ? t - 3 : jx) / 2);
      if (t < tbs) begin
        chk("R8 bit_err before scan", bit_err_cnt, exp_bit);
        chk("R9 frame_err before scan", frame_err_cnt, exp_ferr);
      end else if (t >= tfin) begin
        chk("R8 bit_err after scan", bit_err_cnt, exp_bit + errs);
        chk("R9 frame_err after fail", frame_err_cnt, exp_ferr + 1);
      end
      start = extra_start && (t == 4);
      @(negedge clk);
    end
    start = 1'b0;
    if (!ok) begin exp_bit += errs; exp_ferr++; end
    exp_stat = nstat;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 0);
    chk("R1 bit_err", bit_err_cnt, 0);
    chk("R1 frame_err", frame_err_cnt, 0);
    chk("R1 dec_ctrl", {dec_rst, dec_load, dec_run, result_valid}, 0);

    // R12 LLR and transmitted-frame loading
    for (int i = 0; i < LLRN; i++) host_write(2'd0, i, WW'(16'h1111 * (i + 1) ^ 16'h5A3C));
    for (int i = 0; i < LLRN; i++)
      chk("R12 llr word", dec_llr[i*WW +: WW], WW'(16'h1111 * (i + 1) ^ 16'h5A3C));
    for (int g = 0; g < GN; g++) host_write(2'd1, g, WW'(16'hC3A5 + 16'h0F0F * g));

    // R1 default budget of 100: give-up after 201 run cycles, one error bit
    run_trial(-1, gold_m ^ 64'h1, 1'b0);
    // R4 clean decode after 3 iterations
    run_trial(3, gold_m, 1'b0);
    // R12 budget write, R6 give-up with the transmitted frame (no bit errors, one frame error)
    host_write(2'd2, 0, 16'd5);
    run_trial(-1, gold_m, 1'b0);
    // R7 done in the same cycle as the limit: clean and wrong
    run_trial(5, gold_m, 1'b0);
    run_trial(5, gold_m ^ 64'h8000_0000_0001_0010, 1'b0);
    // R5 wrong codeword with errors in every word, R2 start while busy ignored
    run_trial(2, gold_m ^ 64'h0007_00F0_0300_8001, 1'b1);
    // R4 immediate convergence
    run_trial(0, gold_m, 1'b0);
    // R6 zero budget gives up in the first run cycle
    host_write(2'd2, 0, 16'd0);
    run_trial(-1, ~gold_m, 1'b0);
    // R11 clear
    clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0;
    chk("R11 bit_err cleared", bit_err_cnt, 0);
    chk("R11 frame_err cleared", frame_err_cnt, 0);
    exp_bit = 0; exp_ferr = 0;
    host_write(2'd2, 0, 16'd4);
    run_trial(7, gold_m ^ 64'h3, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule